// File: doc/BRIEF.md
# Endpoint-Zero Control Stage Sequencer

This block follows a USB control transfer on endpoint 0 through its setup, data and status stages. It is driven by token events that the packet decoder has already identified (SETUP, IN, OUT) and by the eight request bytes that come after a SETUP token. Firmware reaches it through a few write strobes. For every data or status token the block registers a handshake decision: ACK, NAK or STALL. It also pulses interrupts when setup ends, when the stage changes and when a buffer becomes ready.

Each SETUP token sets a lock flag. The same token forces the endpoint response field to NAK and clears the control-complete bit. Both stay frozen until firmware releases the lock. Two standard requests, SET_ADDRESS and SET_CONFIGURATION, are finished by the block with no firmware involvement. Every other request is handed to firmware through an interrupt.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: After reset, `stage` is 00 (idle). `lock_flag`, `rsp_field`, `ctl_done`, `dev_addr`, `cfg_value` and `configured` are all zero. `hs_valid` is 0 and no interrupt is asserted.
- R2: After a SETUP token, eight bytes come in on `setup_byte_valid`. Byte 0 and byte 1 become `req_word` (byte 0 in bits 7:0). Bytes 2-3 become `value`, bytes 4-5 become `index` and bytes 6-7 become `length`, each with the low byte first. One cycle after the eighth byte, `hs_valid` is 1 with `hs_code` 00 (ACK).
- R3: A SETUP token (`tok_kind` 11) has these effects on the next cycle: `lock_flag` is 1, `rsp_field` is 00, `ctl_done` is 0 and `stage` is 01. This holds even when firmware clears the lock or writes those fields in the same cycle.
- R4: Firmware writes to `rsp_field` and `ctl_done` are ignored while `lock_flag` is 1. After `fw_clr_lock` has taken effect, they are accepted.
- R5: In the setup stage, an IN (10) or OUT (01) token with a nonzero `length` moves to the data stage (10). A data token gets ACK only when `rsp_field` is 01 and the buffer is ready: `tx_loaded` for IN, `rx_empty` for OUT. An ACK also pulses `irq_buf_ready`. Every other case gets NAK (01).
- R6: In the data stage, a token of the opposite direction moves to the status stage (11) and pulses `irq_status`. A status token gets ACK only when `rsp_field` is 01 and `ctl_done` is 1. Otherwise it gets NAK.
- R7: Take a request with zero length that the block does not handle itself. It gives no `irq_setup`. The first IN or OUT token goes straight to the status stage and pulses `irq_status`, which stands in for the setup-complete interrupt.
- R8: A request the block does not handle itself, with nonzero length, pulses `irq_setup` for one cycle. The pulse comes together with the setup ACK.
- R9: SET_ADDRESS is request word 16'h0500. The new address is `value[6:0]`. `dev_addr` takes it only after a status-stage IN token has been ACKed, and takes effect the cycle after that handshake. The status stage gets ACK whatever the firmware fields hold. No `irq_setup` is raised.
- R10: SET_CONFIGURATION is request word 16'h0900. The block loads `value[7:0]` into `cfg_value` and sets `configured` exactly when that byte is nonzero. No `irq_setup` is raised.
- R11: While `rsp_field` is 10, every data-stage or status-stage token gets STALL (10). This lasts until the next SETUP, which forces the field back to 00.
- R12: A SETUP token in the middle of a transfer restarts the sequence. The stage returns to setup and the new request fields replace the old ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | A token event is present this cycle |
| tok_kind | input | 2 | Token type: 01 OUT, 10 IN, 11 SETUP |
| setup_byte_valid | input | 1 | A setup request byte is present |
| setup_byte | input | 8 | Setup request byte |
| rx_empty | input | 1 | Receive buffer can take an OUT packet |
| tx_loaded | input | 1 | Transmit buffer holds IN data |
| fw_clr_lock | input | 1 | Firmware releases the lock flag |
| fw_wr_rsp | input | 1 | Firmware writes the response field |
| fw_rsp | input | 2 | Response field value: 00 NAK, 01 ACK, 10 STALL |
| fw_wr_done | input | 1 | Firmware writes the control-complete bit |
| fw_done | input | 1 | Control-complete value |
| stage | output | 2 | 00 idle, 01 setup, 10 data, 11 status |
| lock_flag | output | 1 | Set on SETUP; freezes the firmware fields |
| rsp_field | output | 2 | Current endpoint response field |
| ctl_done | output | 1 | Current control-complete bit |
| req_word | output | 16 | Request type (low byte) and request code (high byte) |
| value | output | 16 | Request value field |
| index | output | 16 | Request index field |
| length | output | 16 | Request length field |
| hs_valid | output | 1 | A handshake decision is presented |
| hs_code | output | 2 | 00 ACK, 01 NAK, 10 STALL |
| irq_setup | output | 1 | Setup-complete interrupt pulse |
| irq_status | output | 1 | Status-stage entry interrupt pulse |
| irq_buf_ready | output | 1 | Buffer-ready interrupt pulse |
| dev_addr | output | 7 | Device address in effect |
| cfg_value | output | 8 | Configuration value |
| configured | output | 1 | Nonzero configuration is active |

## Verification
A SETUP token can arrive in the same cycle as a firmware write that releases the lock and rewrites the response field and the control-complete bit. The bench drives all four strobes at one clock edge, with the firmware asking for ACK and completion. It then reads back the lock flag, response field and control-complete bit, and expects 1, 00 and 0: the token wins. A later status-direction token must then be NAKed, which shows that the lost firmware write also had no effect at the handshake output.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;
  typedef enum logic [1:0] {
    STG_IDLE   = 2'b00,
    STG_SETUP  = 2'b01,
    STG_DATA   = 2'b10,
    STG_STATUS = 2'b11
  } stage_t;

  typedef enum logic [1:0] {
    AUTO_NONE = 2'b00,
    AUTO_ADDR = 2'b01,
    AUTO_CFG  = 2'b10
  } auto_t;

  localparam logic [1:0] TOK_OUT   = 2'b01;
  localparam logic [1:0] TOK_IN    = 2'b10;
  localparam logic [1:0] TOK_SETUP = 2'b11;

  localparam logic [1:0] HS_ACK   = 2'b00;
  localparam logic [1:0] HS_NAK   = 2'b01;
  localparam logic [1:0] HS_STALL = 2'b10;

  localparam logic [1:0] RSP_ACK   = 2'b01;
  localparam logic [1:0] RSP_STALL = 2'b10;

  localparam logic [7:0] STD_OUT_DEVICE = 8'h00;
  localparam logic [7:0] CODE_SET_ADDR  = 8'h05;
  localparam logic [7:0] CODE_SET_CFG   = 8'h09;

  function automatic auto_t decode_auto(input logic [15:0] req);
    if (req[7:0] == STD_OUT_DEVICE && req[15:8] == CODE_SET_ADDR) return AUTO_ADDR;
    if (req[7:0] == STD_OUT_DEVICE && req[15:8] == CODE_SET_CFG)  return AUTO_CFG;
    return AUTO_NONE;
  endfunction
endpackage

// File: rtl/ep0_setup_capture.sv
module ep0_setup_capture #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          byte_valid,
  input  logic [BYTE_W-1:0]             byte_in,
  output logic                          done,
  output logic [NUM_BYTES*BYTE_W-1:0]   bytes_flat
);
  localparam int CNT_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BYTES - 1);

  logic [BYTE_W-1:0] store [NUM_BYTES];
  logic [CNT_W-1:0]  cnt;
  logic              busy;

  // request byte storage, no reset so it may map to distributed RAM
  always_ff @(posedge clk) begin
    if (busy && byte_valid && !start) store[cnt] <= byte_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy && byte_valid) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_flat
    assign bytes_flat[g*BYTE_W +: BYTE_W] = store[g];
  end

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R2
  done_after_byte_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(byte_valid));
endmodule

// File: rtl/ep0_resp_regs.sv
module ep0_resp_regs #(
  parameter int RSP_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             setup_tok,
  input  logic             fw_clr_lock,
  input  logic             fw_wr_rsp,
  input  logic [RSP_W-1:0] fw_rsp,
  input  logic             fw_wr_done,
  input  logic             fw_done,
  output logic             lock_flag,
  output logic [RSP_W-1:0] rsp_field,
  output logic             ctl_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_flag <= 1'b0;
      rsp_field <= '0;
      ctl_done  <= 1'b0;
    end else if (setup_tok) begin
      lock_flag <= 1'b1;
      rsp_field <= '0;
      ctl_done  <= 1'b0;
    end else begin
      if (fw_clr_lock) lock_flag <= 1'b0;
      if (!lock_flag) begin
        if (fw_wr_rsp)  rsp_field <= fw_rsp;
        if (fw_wr_done) ctl_done  <= fw_done;
      end
    end
  end

  // R3
  setup_force_chk: assert property (@(posedge clk) disable iff (rst)
    setup_tok |=> lock_flag && rsp_field == '0 && !ctl_done);
  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lock_flag && !setup_tok |=> $stable(rsp_field) && $stable(ctl_done));
endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_seq_pkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tok_valid,
  input  logic [1:0]         tok_kind,
  input  logic               setup_done,
  input  logic [FIELD_W-1:0] req_word,
  input  logic [FIELD_W-1:0] length,
  input  logic [1:0]         rsp_field,
  input  logic               ctl_done,
  input  logic               rx_empty,
  input  logic               tx_loaded,
  output stage_t             stage_q,
  output logic               hs_valid,
  output logic [1:0]         hs_code,
  output logic               irq_setup,
  output logic               irq_status,
  output logic               irq_buf_ready,
  output logic               addr_latch,
  output logic               cfg_load,
  output logic               addr_commit
);
  logic   ready_q, nodata_q, dir_in_q;
  auto_t  auto_q, auto_dec;
  stage_t stage_d;
  logic   dir_d, enter_status;
  logic [1:0] code_d;
  logic   tok_setup, tok_io, tok_is_in, stall, buf_ok;

  assign tok_setup = tok_valid && tok_kind == TOK_SETUP;
  assign tok_io    = tok_valid && (tok_kind == TOK_IN || tok_kind == TOK_OUT);
  assign tok_is_in = tok_kind == TOK_IN;
  assign stall     = rsp_field == RSP_STALL;
  assign buf_ok    = tok_is_in ? tx_loaded : rx_empty;
  assign auto_dec  = decode_auto(req_word);

  always_comb begin
    stage_d      = stage_q;
    dir_d        = dir_in_q;
    enter_status = 1'b0;
    case (stage_q)
      STG_SETUP: if (ready_q) begin
        if (nodata_q) begin
          stage_d      = STG_STATUS;
          enter_status = 1'b1;
        end else begin
          stage_d = STG_DATA;
          dir_d   = tok_is_in;
        end
      end
      STG_DATA: if (tok_is_in != dir_in_q) begin
        stage_d      = STG_STATUS;
        enter_status = 1'b1;
      end
      default: ;
    endcase
    case (stage_d)
      STG_DATA:   code_d = stall ? HS_STALL :
                           (rsp_field == RSP_ACK && buf_ok) ? HS_ACK : HS_NAK;
      STG_STATUS: code_d = (auto_q != AUTO_NONE) ? HS_ACK :
                           stall ? HS_STALL :
                           (rsp_field == RSP_ACK && ctl_done) ? HS_ACK : HS_NAK;
      default:    code_d = stall ? HS_STALL : HS_NAK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q       <= STG_IDLE;
      ready_q       <= 1'b0;
      nodata_q      <= 1'b0;
      dir_in_q      <= 1'b0;
      auto_q        <= AUTO_NONE;
      hs_valid      <= 1'b0;
      hs_code       <= HS_NAK;
      irq_setup     <= 1'b0;
      irq_status    <= 1'b0;
      irq_buf_ready <= 1'b0;
      addr_latch    <= 1'b0;
      cfg_load      <= 1'b0;
      addr_commit   <= 1'b0;
    end else begin
      hs_valid      <= 1'b0;
      irq_setup     <= 1'b0;
      irq_status    <= 1'b0;
      irq_buf_ready <= 1'b0;
      addr_latch    <= 1'b0;
      cfg_load      <= 1'b0;
      addr_commit   <= 1'b0;
      if (tok_setup) begin
        stage_q <= STG_SETUP;
        ready_q <= 1'b0;
        auto_q  <= AUTO_NONE;
      end else if (setup_done) begin
        ready_q    <= 1'b1;
        nodata_q   <= length == '0;
        auto_q     <= auto_dec;
        hs_valid   <= 1'b1;
        hs_code    <= HS_ACK;
        irq_setup  <= auto_dec == AUTO_NONE && length != '0;
        addr_latch <= auto_dec == AUTO_ADDR;
        cfg_load   <= auto_dec == AUTO_CFG;
      end else if (tok_io) begin
        stage_q       <= stage_d;
        dir_in_q      <= dir_d;
        hs_valid      <= 1'b1;
        hs_code       <= code_d;
        irq_status    <= enter_status && auto_q == AUTO_NONE;
        irq_buf_ready <= stage_d == STG_DATA && code_d == HS_ACK;
        addr_commit   <= stage_d == STG_STATUS && auto_q == AUTO_ADDR &&
                         tok_is_in && code_d == HS_ACK;
      end
    end
  end

  // R6
  dir_change_chk: assert property (@(posedge clk) disable iff (rst)
    tok_io && stage_q == STG_DATA && (tok_is_in != dir_in_q) |=> stage_q == STG_STATUS && hs_valid);
  // R6
  status_ack_chk: assert property (@(posedge clk) disable iff (rst)
    tok_io && stage_q == STG_STATUS && auto_q == AUTO_NONE && !(rsp_field == RSP_ACK && ctl_done)
    |=> hs_code != HS_ACK);
  // R11
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    tok_io && stall && auto_q == AUTO_NONE && (stage_q == STG_DATA || stage_q == STG_STATUS)
    |=> hs_valid && hs_code == HS_STALL);
endmodule

// File: rtl/ep0_ctrl_seq.sv
module ep0_ctrl_seq
  import ep0_seq_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_SETUP = 8,
  parameter int ADDR_W    = 7,
  parameter int CFG_W     = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tok_valid,
  input  logic [1:0]          tok_kind,
  input  logic                setup_byte_valid,
  input  logic [BYTE_W-1:0]   setup_byte,
  input  logic                rx_empty,
  input  logic                tx_loaded,
  input  logic                fw_clr_lock,
  input  logic                fw_wr_rsp,
  input  logic [1:0]          fw_rsp,
  input  logic                fw_wr_done,
  input  logic                fw_done,
  output logic [1:0]          stage,
  output logic                lock_flag,
  output logic [1:0]          rsp_field,
  output logic                ctl_done,
  output logic [2*BYTE_W-1:0] req_word,
  output logic [2*BYTE_W-1:0] value,
  output logic [2*BYTE_W-1:0] index,
  output logic [2*BYTE_W-1:0] length,
  output logic                hs_valid,
  output logic [1:0]          hs_code,
  output logic                irq_setup,
  output logic                irq_status,
  output logic                irq_buf_ready,
  output logic [ADDR_W-1:0]   dev_addr,
  output logic [CFG_W-1:0]    cfg_value,
  output logic                configured
);
  localparam int FIELD_W = 2 * BYTE_W;

  logic [NUM_SETUP*BYTE_W-1:0] bytes_flat;
  logic   setup_done, setup_tok, addr_latch, cfg_load, addr_commit;
  logic [ADDR_W-1:0] addr_pend;
  stage_t stage_q;

  assign setup_tok = tok_valid && tok_kind == TOK_SETUP;

  ep0_setup_capture #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_SETUP)) u_cap (
    .clk(clk), .rst(rst), .start(setup_tok),
    .byte_valid(setup_byte_valid), .byte_in(setup_byte),
    .done(setup_done), .bytes_flat(bytes_flat)
  );

  assign req_word = bytes_flat[0*FIELD_W +: FIELD_W];
  assign value    = bytes_flat[1*FIELD_W +: FIELD_W];
  assign index    = bytes_flat[2*FIELD_W +: FIELD_W];
  assign length   = bytes_flat[3*FIELD_W +: FIELD_W];

  ep0_resp_regs #(.RSP_W(2)) u_rsp (
    .clk(clk), .rst(rst), .setup_tok(setup_tok),
    .fw_clr_lock(fw_clr_lock), .fw_wr_rsp(fw_wr_rsp), .fw_rsp(fw_rsp),
    .fw_wr_done(fw_wr_done), .fw_done(fw_done),
    .lock_flag(lock_flag), .rsp_field(rsp_field), .ctl_done(ctl_done)
  );

  ep0_stage_fsm #(.FIELD_W(FIELD_W)) u_fsm (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .setup_done(setup_done), .req_word(req_word), .length(length),
    .rsp_field(rsp_field), .ctl_done(ctl_done),
    .rx_empty(rx_empty), .tx_loaded(tx_loaded),
    .stage_q(stage_q), .hs_valid(hs_valid), .hs_code(hs_code),
    .irq_setup(irq_setup), .irq_status(irq_status), .irq_buf_ready(irq_buf_ready),
    .addr_latch(addr_latch), .cfg_load(cfg_load), .addr_commit(addr_commit)
  );

  assign stage = stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_pend  <= '0;
      dev_addr   <= '0;
      cfg_value  <= '0;
      configured <= 1'b0;
    end else begin
      if (addr_latch)  addr_pend <= value[ADDR_W-1:0];
      if (addr_commit) dev_addr  <= addr_pend;
      if (cfg_load) begin
        cfg_value  <= value[CFG_W-1:0];
        configured <= |value[CFG_W-1:0];
      end
    end
  end

  // R9
  addr_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dev_addr) |-> $past(addr_commit));
  // R10
  cfg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    configured == (cfg_value != '0));
endmodule

// File: tb/tb_ep0_ctrl_seq.sv
module tb_ep0_ctrl_seq;
  logic clk = 1'b0;
  logic rst;
  logic tok_valid = 0;
  logic [1:0] tok_kind = 0;
  logic setup_byte_valid = 0;
  logic [7:0] setup_byte = 0;
  logic rx_empty = 0, tx_loaded = 0;
  logic fw_clr_lock = 0, fw_wr_rsp = 0, fw_wr_done = 0, fw_done = 0;
  logic [1:0] fw_rsp = 0;
  logic [1:0] stage, rsp_field, hs_code;
  logic lock_flag, ctl_done, hs_valid, irq_setup, irq_status, irq_buf_ready, configured;
  logic [15:0] req_word, value, index, length;
  logic [6:0] dev_addr;
  logic [7:0] cfg_value;

  int checks = 0, errors = 0;
  logic s_hs_valid, s_irq_setup, s_irq_status, s_irq_buf;
  logic [1:0] s_hs_code;

  localparam logic [1:0] K_OUT = 2'b01, K_IN = 2'b10, K_SETUP = 2'b11;
  localparam logic [1:0] ACK = 2'b00, NAK = 2'b01, STALL = 2'b10;

  always #2 clk = ~clk;

  ep0_ctrl_seq dut (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .setup_byte_valid(setup_byte_valid), .setup_byte(setup_byte),
    .rx_empty(rx_empty), .tx_loaded(tx_loaded),
    .fw_clr_lock(fw_clr_lock), .fw_wr_rsp(fw_wr_rsp), .fw_rsp(fw_rsp),
    .fw_wr_done(fw_wr_done), .fw_done(fw_done),
    .stage(stage), .lock_flag(lock_flag), .rsp_field(rsp_field), .ctl_done(ctl_done),
    .req_word(req_word), .value(value), .index(index), .length(length),
    .hs_valid(hs_valid), .hs_code(hs_code), .irq_setup(irq_setup),
    .irq_status(irq_status), .irq_buf_ready(irq_buf_ready),
    .dev_addr(dev_addr), .cfg_value(cfg_value), .configured(configured)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic grab();
    s_hs_valid = hs_valid; s_hs_code = hs_code; s_irq_setup = irq_setup;
    s_irq_status = irq_status; s_irq_buf = irq_buf_ready;
  endtask

  // byte 0 sits in the top byte of pk
  task automatic send_setup(input logic [63:0] pk);
    tok_valid = 1; tok_kind = K_SETUP;
    @(negedge clk);
    tok_valid = 0;
    for (int i = 0; i < 8; i++) begin
      setup_byte_valid = 1; setup_byte = pk[63-8*i -: 8];
      @(negedge clk);
    end
    setup_byte_valid = 0;
    @(negedge clk);
    grab();
  endtask

  task automatic token(input logic [1:0] k);
    tok_valid = 1; tok_kind = k;
    @(negedge clk);
    grab();
    tok_valid = 0;
  endtask

  task automatic fw_unlock_set(input logic [1:0] r, input logic d);
    fw_clr_lock = 1; @(negedge clk); fw_clr_lock = 0;
    fw_wr_rsp = 1; fw_rsp = r; fw_wr_done = 1; fw_done = d;
    @(negedge clk);
    fw_wr_rsp = 0; fw_wr_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 stage", stage, 0); chk("R1 lock", lock_flag, 0);
    chk("R1 rsp", rsp_field, 0); chk("R1 done", ctl_done, 0);
    chk("R1 addr", dev_addr, 0); chk("R1 cfg", {cfg_value, configured}, 0);
    chk("R1 hs/irq", {hs_valid, irq_setup, irq_status, irq_buf_ready}, 0);
  endtask

  task automatic t_control_read();
    send_setup(64'h80_06_00_01_34_12_12_00);
    chk("R2 req_word", req_word, 16'h0680); chk("R2 value", value, 16'h0100);
    chk("R2 index", index, 16'h1234); chk("R2 length", length, 16'h0012);
    chk("R2 setup ack", {s_hs_valid, s_hs_code}, {1'b1, ACK});
    chk("R8 irq_setup", s_irq_setup, 1);
    @(negedge clk); chk("R8 pulse ends", irq_setup, 0);
    chk("R3 lock set", {lock_flag, rsp_field, ctl_done}, {1'b1, 2'b00, 1'b0});
    chk("R3 stage setup", stage, 2'b01);
    // R4: locked writes ignored
    fw_wr_rsp = 1; fw_rsp = 2'b01; fw_wr_done = 1; fw_done = 1;
    @(negedge clk); fw_wr_rsp = 0; fw_wr_done = 0;
    chk("R4 rsp locked", rsp_field, 0); chk("R4 done locked", ctl_done, 0);
    tx_loaded = 1;
    token(K_IN);
    chk("R5 data nak rsp00", {s_hs_valid, s_hs_code}, {1'b1, NAK});
    chk("R5 stage data", stage, 2'b10);
    fw_unlock_set(2'b01, 1'b0);
    chk("R4 accepted", {lock_flag, rsp_field}, {1'b0, 2'b01});
    tx_loaded = 0;
    token(K_IN);
    chk("R5 nak no tx data", s_hs_code, NAK); chk("R5 no irq_buf", s_irq_buf, 0);
    tx_loaded = 1;
    token(K_IN);
    chk("R5 ack", s_hs_code, ACK); chk("R5 irq_buf", s_irq_buf, 1);
    token(K_OUT);
    chk("R6 status entry", stage, 2'b11); chk("R6 irq_status", s_irq_status, 1);
    chk("R6 nak no done", s_hs_code, NAK);
    fw_wr_done = 1; fw_done = 1; @(negedge clk); fw_wr_done = 0;
    token(K_OUT);
    chk("R6 status ack", s_hs_code, ACK); chk("R6 no repeat irq", s_irq_status, 0);
    tx_loaded = 0;
  endtask

  task automatic t_control_write();
    send_setup(64'h40_01_00_00_00_00_04_00);
    fw_unlock_set(2'b01, 1'b0);
    rx_empty = 0;
    token(K_OUT);
    chk("R5 out nak buf full", s_hs_code, NAK);
    rx_empty = 1;
    token(K_OUT);
    chk("R5 out ack", {s_hs_code, s_irq_buf}, {ACK, 1'b1});
    token(K_IN);
    chk("R6 in status", {stage, s_irq_status}, {2'b11, 1'b1});
    rx_empty = 0;
  endtask

  task automatic t_nodata();
    send_setup(64'h40_03_01_00_00_00_00_00);
    chk("R7 no irq_setup", s_irq_setup, 0);
    token(K_IN);
    chk("R7 status direct", stage, 2'b11); chk("R7 irq_status", s_irq_status, 1);
    chk("R7 nak", s_hs_code, NAK);
  endtask

  task automatic t_same_cycle();
    send_setup(64'h40_03_01_00_00_00_00_00);
    fw_unlock_set(2'b01, 1'b1);
    tok_valid = 1; tok_kind = K_SETUP;
    fw_clr_lock = 1; fw_wr_rsp = 1; fw_rsp = 2'b01; fw_wr_done = 1; fw_done = 1;
    @(negedge clk);
    tok_valid = 0; fw_clr_lock = 0; fw_wr_rsp = 0; fw_wr_done = 0;
    chk("R3 setup wins", {lock_flag, rsp_field, ctl_done}, {1'b1, 2'b00, 1'b0});
    for (int i = 0; i < 8; i++) begin
      setup_byte_valid = 1; setup_byte = 8'h00; @(negedge clk);
    end
    setup_byte_valid = 0; @(negedge clk);
    token(K_IN);
    chk("R3 status nak after race", s_hs_code, NAK);
  endtask

  task automatic t_stall();
    send_setup(64'hC0_10_00_00_00_00_08_00);
    fw_unlock_set(2'b10, 1'b0);
    tx_loaded = 1;
    token(K_IN);
    chk("R11 stall data", s_hs_code, STALL);
    token(K_OUT);
    chk("R11 stall status", s_hs_code, STALL);
    tx_loaded = 0;
    send_setup(64'hC0_10_00_00_00_00_08_00);
    chk("R11 setup clears", rsp_field, 2'b00);
    token(K_IN);
    chk("R11 nak after setup", s_hs_code, NAK);
  endtask

  task automatic t_restart();
    send_setup(64'h80_06_00_02_00_00_40_00);
    fw_unlock_set(2'b01, 1'b0);
    tx_loaded = 1; token(K_IN); tx_loaded = 0;
    chk("R12 in data", stage, 2'b10);
    tok_valid = 1; tok_kind = K_SETUP; @(negedge clk); tok_valid = 0;
    chk("R12 back to setup", stage, 2'b01);
    chk("R12 lock", {lock_flag, rsp_field}, {1'b1, 2'b00});
    for (int i = 0; i < 8; i++) begin
      setup_byte_valid = 1; setup_byte = (i == 1) ? 8'h08 : ((i == 0) ? 8'h80 : 8'h00);
      if (i == 6) setup_byte = 8'h01;
      @(negedge clk);
    end
    setup_byte_valid = 0; @(negedge clk);
    chk("R12 new req", {req_word, length}, {16'h0880, 16'h0001});
  endtask

  task automatic t_set_address();
    send_setup(64'h00_05_AA_00_00_00_00_00);
    chk("R9 no irq_setup", s_irq_setup, 0);
    repeat (3) @(negedge clk);
    chk("R9 addr held", dev_addr, 0);
    token(K_IN);
    chk("R9 auto ack", {s_hs_valid, s_hs_code}, {1'b1, ACK});
    chk("R9 addr same cycle", dev_addr, 0);
    @(negedge clk);
    chk("R9 addr applied", dev_addr, 7'h2A);
  endtask

  task automatic t_set_config();
    send_setup(64'h00_09_03_00_00_00_00_00);
    chk("R10 no irq_setup", s_irq_setup, 0);
    repeat (3) @(negedge clk);
    chk("R10 cfg", {cfg_value, configured}, {8'h03, 1'b1});
    send_setup(64'h00_09_00_00_00_00_00_00);
    repeat (3) @(negedge clk);
    chk("R10 cfg zero", {cfg_value, configured}, {8'h00, 1'b0});
  endtask

  logic finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_control_read();
    t_control_write();
    t_nodata();
    t_same_cycle();
    t_stall();
    t_restart();
    t_set_address();
    t_set_config();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule